// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Port

This block is a bank of general-purpose I/O pins, `WIDTH` wide. Software controls it through three registers on a small register bus. A direction register sets each pin as input or output. An output latch holds the values to drive. A port view returns the sampled pin levels, and a write to it goes into the output latch.

Each pin may also be claimed by one on-chip peripheral. A peripheral takes the pin's driver and data only while it is both enabled and asserting its own output-enable. Otherwise the port registers keep control.

Pin levels pass through a two-stage synchronizer. The synchronized value feeds both the port read path and the peripheral's input. The peripheral's input is forced to zero while that peripheral is disabled, so the port cannot loop its own output into an idle peripheral.

A parameter mask marks pins that do not exist. On those bits the registers read zero, writes are dropped and the pin is never driven.

Top module: `gpio_share_port`

## Requirements
- R1: A direction bit of 1 turns the pin driver off (`pad_oe_o` bit 0). A direction bit of 0 drives the latch bit onto `pad_out_o`, with `pad_oe_o` bit 1, unless a peripheral owns the pin.
- R2: After reset, every implemented direction bit reads 1, the latch reads 0, and no pin is driven.
- R3: Address 2 reads the latch. A write to address 2 loads the latch at the next clock edge.
- R4: Address 1 reads the pin levels after two clock edges of synchronization. A pin change is not visible after only one edge.
- R5: A write to address 1 loads the latch and leaves the sampled pin levels unchanged.
- R6: When a pin's peripheral enable and peripheral output-enable are both 1, `pad_oe_o` is 1 and `pad_out_o` equals the peripheral data. The port direction and latch have no effect on that pin.
- R7: When the peripheral enable is 0, or its output-enable is 0, the port direction and latch control the pin as in R1.
- R8: The pin level stays readable at address 1 while a peripheral owns the pin.
- R9: Bits that are 0 in `IMPL_MASK` read 0 at addresses 0, 1 and 2, ignore writes, and keep `pad_oe_o` at 0. The default mask is 8'h7F, so bit 7 is unimplemented.
- R10: `periph_in_o` equals the synchronized pin level on pins whose peripheral enable is 1, and is 0 on pins whose peripheral enable is 0.
- R11: Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe, one cycle |
| addr_i | input | 2 | Register select: 0 direction, 1 port, 2 latch |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Combinational read data |
| periph_en_i | input | WIDTH | Per-pin peripheral enable |
| periph_oe_i | input | WIDTH | Per-pin peripheral output-enable |
| periph_out_i | input | WIDTH | Per-pin peripheral output data |
| periph_in_o | output | WIDTH | Per-pin input data delivered to the peripheral |
| pad_in_i | input | WIDTH | Pin level from the pad |
| pad_out_o | output | WIDTH | Data to the pad driver |
| pad_oe_o | output | WIDTH | Pad driver enable |

## Verification
A corrupted direction or latch bit shows up on `pad_oe_o` or `pad_out_o` in the same cycle it is written. It also shows up on a register read at once. A fault in the synchronizer is visible at address 1 and on `periph_in_o` exactly two edges after a pin change. The bench samples both one edge early and at the expected edge. Ownership faults are caught combinationally on the pad outputs for every combination of enable and output-enable. Masking faults show on bit 7 of every read and on its driver enable.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_PORT = 2'd1,
    SEL_LAT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_share_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] lat_o
);
  reg_sel_e sel;
  logic dir_we, lat_we;
  logic [WIDTH-1:0] dir_q, lat_q;

  assign sel    = reg_sel_e'(addr_i);
  assign dir_we = wr_i && (sel == SEL_DIR);
  // port address writes land in the latch
  assign lat_we = wr_i && ((sel == SEL_LAT) || (sel == SEL_PORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= IMPL_MASK;
      lat_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata_i & IMPL_MASK;
      if (lat_we) lat_q <= wdata_i & IMPL_MASK;
    end
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;

  assert_lat_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd1) |=> (lat_q == $past(wdata_i & IMPL_MASK)));
  assert_lat_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2) |=> (lat_q == $past(wdata_i & IMPL_MASK)));
  assert_no_write_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || addr_i == 2'd3) |=> ($stable(dir_q) && $stable(lat_q)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter bit IMPL = 1'b1
) (
  input  logic dir_i,
  input  logic lat_i,
  input  logic p_en_i,
  input  logic p_oe_i,
  input  logic p_out_i,
  input  logic sync_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic p_in_o
);
  logic own;

  assign own       = IMPL && p_en_i && p_oe_i;
  assign pad_oe_o  = IMPL && (own || !dir_i);
  assign pad_out_o = IMPL && (own ? p_out_i : lat_i);
  // loop-through gate: idle peripheral sees zero
  assign p_in_o    = IMPL && p_en_i && sync_i;
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'h7F,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] periph_en_i,
  input  logic [WIDTH-1:0] periph_oe_i,
  input  logic [WIDTH-1:0] periph_out_i,
  output logic [WIDTH-1:0] periph_in_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  logic [WIDTH-1:0] dir, lat, pin_sync;

  gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .dir_o(dir), .lat_o(lat)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i & IMPL_MASK), .q_o(pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_mux #(.IMPL(IMPL_MASK[i])) u_mux (
      .dir_i(dir[i]), .lat_i(lat[i]),
      .p_en_i(periph_en_i[i]), .p_oe_i(periph_oe_i[i]), .p_out_i(periph_out_i[i]),
      .sync_i(pin_sync[i]),
      .pad_out_o(pad_out_o[i]), .pad_oe_o(pad_oe_o[i]), .p_in_o(periph_in_o[i])
    );
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_DIR:  rdata_o = dir & IMPL_MASK;
      SEL_PORT: rdata_o = pin_sync & IMPL_MASK;
      SEL_LAT:  rdata_o = lat & IMPL_MASK;
      default:  rdata_o = '0;
    endcase
  end

  assert_unimpl_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~IMPL_MASK) == '0) && ((rdata_o & ~IMPL_MASK) == '0));
  assert_loop_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_in_o & ~periph_en_i) == '0);
  assert_owner_drives_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & periph_en_i & periph_oe_i & IMPL_MASK) == (periph_en_i & periph_oe_i & IMPL_MASK)));
  assert_owner_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ periph_out_i) & periph_en_i & periph_oe_i & IMPL_MASK) == '0);
  assert_input_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & dir & ~(periph_en_i & periph_oe_i)) == '0);
endmodule

// File: tb/sim_gpio_share_port.sv
module sim_gpio_share_port;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic wr = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic [W-1:0] p_en = 0, p_oe = 0, p_out = 0, p_in;
  logic [W-1:0] ext = 0, pad_in, pad_out, pad_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // pad model: driven pins loop back, others follow external drive
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_share_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .periph_en_i(p_en), .periph_oe_i(p_oe), .periph_out_i(p_out),
    .periph_in_o(p_in), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle2();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    rreg(2'd0, d); chk("R2 dir", d, 8'h7F);
    rreg(2'd2, d); chk("R2 lat", d, 8'h00);
    chk("R2 oe", pad_oe, 8'h00);
  endtask

  task automatic t_latch();
    logic [W-1:0] d;
    wreg(2'd2, 8'hA5);
    rreg(2'd2, d); chk("R3/R9 latch rw", d, 8'h25);
    chk("R1 inputs undriven", pad_oe, 8'h00);
  endtask

  task automatic t_dir();
    logic [W-1:0] d;
    wreg(2'd0, 8'h00);
    chk("R1 all outputs oe", pad_oe, 8'h7F);
    chk("R1 latch on pad", pad_out, 8'h25);
    wreg(2'd0, 8'hF0);
    chk("R1 mixed oe", pad_oe, 8'h0F);
    rreg(2'd0, d); chk("R9 dir bit7", d, 8'h70);
    wreg(2'd0, 8'hFF);
  endtask

  task automatic t_port_read();
    logic [W-1:0] d;
    settle2();
    @(negedge clk); ext = 8'hC3;
    @(negedge clk); rreg(2'd1, d); chk("R4 one edge old", d, 8'h00);
    @(negedge clk); rreg(2'd1, d); chk("R4/R9 two edges", d, 8'h43);
  endtask

  task automatic t_port_write();
    logic [W-1:0] d;
    wreg(2'd1, 8'h1E);
    rreg(2'd2, d); chk("R5 latch loaded", d, 8'h1E);
    chk("R5 pins undriven", pad_oe, 8'h00);
    settle2();
    rreg(2'd1, d); chk("R5 pins unchanged", d, 8'h43);
  endtask

  task automatic t_periph();
    logic [W-1:0] d;
    ext = 8'h00;
    wreg(2'd2, 8'h0F);
    wreg(2'd0, 8'h00);
    @(negedge clk); p_en = 8'h03; p_oe = 8'h01; p_out = 8'h00; #1;
    chk("R6 owner data", pad_out, 8'h0E);
    chk("R6/R7 oe", pad_oe, 8'h7F);
    wreg(2'd0, 8'h7F);
    @(negedge clk); p_out = 8'h01; p_oe = 8'h05; p_en = 8'h03; #1;
    chk("R6 owner over input dir", pad_oe, 8'h01);
    chk("R7 oe without enable", pad_out, 8'h0F);
    settle2();
    rreg(2'd1, d); chk("R8 owned pin readable", d, 8'h01);
  endtask

  task automatic t_loop();
    @(negedge clk); p_oe = 0; p_out = 0; p_en = 8'h05; ext = 8'hFF;
    settle2(); #1;
    chk("R10 enabled pins see input", p_in, 8'h05);
    @(negedge clk); p_en = 8'h00; #1;
    chk("R10 disabled gated", p_in, 8'h00);
    @(negedge clk); p_en = 8'h80; #1;
    chk("R9 unimplemented periph in", p_in, 8'h00);
    p_en = 0;
  endtask

  task automatic t_nullreg();
    logic [W-1:0] d;
    wreg(2'd3, 8'h00);
    rreg(2'd3, d); chk("R11 addr3 reads zero", d, 8'h00);
    rreg(2'd0, d); chk("R11 dir kept", d, 8'h7F);
    rreg(2'd2, d); chk("R11 lat kept", d, 8'h0F);
  endtask

  initial begin
    #25 rst_n = 1;
    t_reset();
    t_latch();
    t_dir();
    t_port_read();
    t_port_write();
    t_periph();
    t_loop();
    t_nullreg();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule